// File: doc/BRIEF.md
# Hash Engine Register Front End

This block is the memory-mapped register front end of a 160-bit hash engine. A host on a simple chip-select bus writes a 512-bit message block as sixteen 32-bit words, then writes a start command. One command requests the first block of a new message and the other requests a continuation block. The block turns each command into a single-cycle start pulse towards the compression core. It presents the stored block to the core on a flat 512-bit bus. It reads the core's ready and valid flags and its 160-bit digest back out as 32-bit words.

The expected host sequence has three steps. The host writes the command value, then writes zero to the command register, then polls the status word until it is nonzero. After that it reads the digest. Reads are combinational, so data is returned within the same clock period as the access. Three identification words, two for a name and one for a version, are fixed by parameters.

Top module: `hash_regif`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, every block word and the command register are zero, so `core_block` is all zero and `core_init` and `core_next` are low.
- R2: Reads at 0x00 and 0x01 return the two name words, and a read at 0x02 returns the version word. All three come from parameters, and writes to these addresses change nothing.
- R3: A write to 0x08 stores `wdata[1:0]` as the command bits (bit 0 = start new message, bit 1 = continue message). A read of 0x08 returns them with bits 31:2 zero.
- R4: A write to 0x08 that moves command bit 0 from 0 to 1 raises `core_init` for exactly the one cycle after that write edge. A write that leaves bit 0 at 1 raises no pulse.
- R5: The same rule applies to command bit 1 and `core_next`.
- R6: A read of 0x09 returns `core_ready` in bit 0 and `core_valid` in bit 1, with all other bits zero. Writes to 0x09 are ignored.
- R7: A write to address 0x10+i (i = 0..15) stores the word into `core_block[511-32*i -: 32]`, so 0x10 holds the most significant word. A read of the same address returns it.
- R8: A read of 0x20+j (j = 0..4) returns `core_digest[159-32*j -: 32]`. Writes to 0x20..0x24 are ignored.
- R9: A read of any other address returns zero, and `rdata` is zero whenever `cs` is low or `we` is high.
- R10: State changes only on a clock edge where both `cs` and `we` are high. Asserting `we` without `cs` leaves `core_block` and the command bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Access select |
| we | input | 1 | 1 = write, 0 = read (when `cs` is high) |
| addr | input | 8 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| core_init | output | 1 | One-cycle start pulse for a new message |
| core_next | output | 1 | One-cycle start pulse for a continuation block |
| core_block | output | 512 | Stored message block, word at 0x10 in the top bits |
| core_ready | input | 1 | Core idle flag |
| core_valid | input | 1 | Core digest valid flag |
| core_digest | input | 160 | Core digest |

## Verification
The block words are loaded with a distinct value per index, then read back. A swapped or reversed word order therefore shows up both on `core_block` and in the read data. The command register is driven through set, hold, clear, both-bits and upper-bit-garbage writes. This separates edge-triggered pulses from level-driven ones, and separates a bit 0 pulse from a bit 1 pulse. Status is tried with all four ready/valid combinations to catch swapped bits. Unmapped addresses, idle cycles, writes without `cs`, writes to read-only words and a reset in the middle of the run show that nothing leaks through or survives where it should not.

// File: rtl/hash_regif_pkg.sv
// Shared constants and types of the hash engine register front end.
// Assumes the block word count is at least the digest word count.
package hash_regif_pkg;
    parameter int WORD_W    = 32;
    parameter int ADDR_W    = 8;
    parameter int BLK_WORDS = 16;
    parameter int DIG_WORDS = 5;
    parameter int CMD_W     = 2;

    parameter int BLK_W  = WORD_W * BLK_WORDS;
    parameter int DIG_W  = WORD_W * DIG_WORDS;
    parameter int BIDX_W = $clog2(BLK_WORDS);
    parameter int DIDX_W = $clog2(DIG_WORDS);

    // Address map; the block and digest windows are word-ordered.
    parameter int ADR_ID0  = 'h00;
    parameter int ADR_ID1  = 'h01;
    parameter int ADR_VER  = 'h02;
    parameter int ADR_CMD  = 'h08;
    parameter int ADR_STAT = 'h09;
    parameter int ADR_BLK  = 'h10;
    parameter int ADR_DIG  = 'h20;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ID0, SEL_ID1, SEL_VER,
        SEL_CMD, SEL_STAT, SEL_BLK, SEL_DIG
    } rsel_e;
endpackage

// File: rtl/hreg_decode.sv
// Address decoder: maps a bus address onto a register group and the
// word index inside the block or digest window.
// Assumes the windows do not overlap.
module hreg_decode
    import hash_regif_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output rsel_e             sel,
    output logic [BIDX_W-1:0] blk_idx,
    output logic [DIDX_W-1:0] dig_idx
);
    int a;
    assign a = int'(addr);

    // Pick the group and the window offset for the current address.
    always_comb begin
        sel     = SEL_NONE;
        blk_idx = '0;
        dig_idx = '0;
        if (a == ADR_ID0) begin
            sel = SEL_ID0;
        end else if (a == ADR_ID1) begin
            sel = SEL_ID1;
        end else if (a == ADR_VER) begin
            sel = SEL_VER;
        end else if (a == ADR_CMD) begin
            sel = SEL_CMD;
        end else if (a == ADR_STAT) begin
            sel = SEL_STAT;
        end else if (a >= ADR_BLK && a < ADR_BLK + BLK_WORDS) begin
            sel     = SEL_BLK;
            blk_idx = BIDX_W'(a - ADR_BLK);
        end else if (a >= ADR_DIG && a < ADR_DIG + DIG_WORDS) begin
            sel     = SEL_DIG;
            dig_idx = DIDX_W'(a - ADR_DIG);
        end
    end
endmodule

// File: rtl/hreg_cmd.sv
// Command register with edge-derived start pulses.
// A pulse fires in the cycle after a write that moves a bit from 0 to 1,
// so a bit left set never restarts the core.
module hreg_cmd
    import hash_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q,
    output logic             init_pls,
    output logic             next_pls
);
    logic [CMD_W-1:0] cmd_d1;
    logic [CMD_W-1:0] rise;

    // Hold the command bits written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_q <= '0;
        else if (wr_en) cmd_q <= wdata;
    end

    // Keep a one-cycle delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_d1 <= '0;
        else        cmd_d1 <= cmd_q;
    end

    assign rise     = cmd_q & ~cmd_d1;
    assign init_pls = rise[0];
    assign next_pls = rise[1];
endmodule

// File: rtl/hreg_block.sv
// Bank of message block words. Word i drives the i-th most significant
// slice of the flat block bus. Assumes single-word writes.
module hreg_block
    import hash_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BIDX_W-1:0] idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic [BLK_W-1:0]  block
);
    logic [WORD_W-1:0] word_q [BLK_WORDS];

    for (genvar i = 0; i < BLK_WORDS; i++) begin : g_word
        // Store one block word when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[i] <= '0;
            else if (wr_en && idx == BIDX_W'(i))
                word_q[i] <= wdata;
        end
        assign block[BLK_W-1-WORD_W*i -: WORD_W] = word_q[i];
    end

    assign rd_word = word_q[idx];
endmodule

// File: rtl/hash_regif.sv
// Top of the hash engine register front end: decodes single-cycle
// chip-select accesses, holds the block and command registers, and
// returns identification, status, block and digest words combinationally.
// Assumes the core samples core_init/core_next on the next clock edge.
module hash_regif
    import hash_regif_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_WORD0 = 32'h68617368,
    parameter logic [WORD_W-1:0] ID_WORD1 = 32'h20726567,
    parameter logic [WORD_W-1:0] VER_WORD = 32'h76312e30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              core_init,
    output logic              core_next,
    output logic [BLK_W-1:0]  core_block,
    input  logic              core_ready,
    input  logic              core_valid,
    input  logic [DIG_W-1:0]  core_digest
);
    rsel_e             sel;
    logic [BIDX_W-1:0] blk_idx;
    logic [DIDX_W-1:0] dig_idx;
    logic              wr;
    logic              rd;
    logic [CMD_W-1:0]  cmd_q;
    logic [WORD_W-1:0] blk_rd;
    logic [WORD_W-1:0] dig_arr [DIG_WORDS];

    assign wr = cs & we;
    assign rd = cs & ~we;

    hreg_decode u_dec (
        .addr    (addr),
        .sel     (sel),
        .blk_idx (blk_idx),
        .dig_idx (dig_idx)
    );

    hreg_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr && sel == SEL_CMD),
        .wdata    (wdata[CMD_W-1:0]),
        .cmd_q    (cmd_q),
        .init_pls (core_init),
        .next_pls (core_next)
    );

    hreg_block u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr && sel == SEL_BLK),
        .idx     (blk_idx),
        .wdata   (wdata),
        .rd_word (blk_rd),
        .block   (core_block)
    );

    for (genvar j = 0; j < DIG_WORDS; j++) begin : g_dig
        assign dig_arr[j] = core_digest[DIG_W-1-WORD_W*j -: WORD_W];
    end

    // Return the addressed word on a read, zero otherwise.
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (sel)
                SEL_ID0:  rdata = ID_WORD0;
                SEL_ID1:  rdata = ID_WORD1;
                SEL_VER:  rdata = VER_WORD;
                SEL_CMD:  rdata = WORD_W'(cmd_q);
                SEL_STAT: rdata = WORD_W'({core_valid, core_ready});
                SEL_BLK:  rdata = blk_rd;
                SEL_DIG:  rdata = dig_arr[dig_idx];
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hash_regif_chk.sv
// Temporal checks on the register front end ports.
module hash_regif_chk
    import hash_regif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic              core_init,
    input logic              core_next,
    input logic [BLK_W-1:0]  core_block,
    input logic              core_ready,
    input logic              core_valid
);
    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !we) |-> rdata == '0);

    // R6
    stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !we && int'(addr) == ADR_STAT)
        |-> rdata == {{(WORD_W-2){1'b0}}, core_valid, core_ready});

    // R4
    init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_init |=> !core_init);

    // R5
    next_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_next |=> !core_next);

    // R10
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && we) |=> $stable(core_block));

    // R7
    blk_top_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && we && int'(addr) == ADR_BLK)
        |=> core_block[BLK_W-1 -: WORD_W] == $past(wdata));
endmodule

bind hash_regif hash_regif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .we         (we),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .core_init  (core_init),
    .core_next  (core_next),
    .core_block (core_block),
    .core_ready (core_ready),
    .core_valid (core_valid)
);

// File: tb/hash_regif_test.sv
`timescale 1ns/1ps
module hash_regif_test;
    localparam logic [31:0] N0 = 32'h48534831;
    localparam logic [31:0] N1 = 32'h5f524547;
    localparam logic [31:0] VR = 32'h30303237;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0;
    logic         we = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         core_init, core_next;
    logic [511:0] core_block;
    logic         core_ready = 1'b0;
    logic         core_valid = 1'b0;
    logic [159:0] core_digest = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    hash_regif #(.ID_WORD0(N0), .ID_WORD1(N1), .VER_WORD(VR)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .core_init(core_init),
        .core_next(core_next), .core_block(core_block),
        .core_ready(core_ready), .core_valid(core_valid),
        .core_digest(core_digest)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, updated on each rising edge.
    logic [31:0] m_blk [16];
    logic [1:0]  m_cmd;
    logic        m_ip, m_np;
    logic        m_inrst;

    always @(posedge clk) begin
        m_inrst <= !rst_n;
        if (!rst_n) begin
            foreach (m_blk[k]) m_blk[k] <= '0;
            m_cmd <= '0;
            m_ip  <= 1'b0;
            m_np  <= 1'b0;
        end else begin
            m_ip <= 1'b0;
            m_np <= 1'b0;
            if (cs && we) begin
                if (addr >= 8'h10 && addr <= 8'h1f)
                    m_blk[int'(addr) - 16] <= wdata;
                if (addr == 8'h08) begin
                    m_cmd <= wdata[1:0];
                    m_ip  <= wdata[0] && !m_cmd[0];
                    m_np  <= wdata[1] && !m_cmd[1];
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd();
        int a = int'(addr);
        if (!(cs && !we)) return '0;
        if (a == 0) return N0;
        if (a == 1) return N1;
        if (a == 2) return VR;
        if (a == 8) return {30'd0, m_cmd};
        if (a == 9) return {30'd0, core_valid, core_ready};
        if (a >= 16 && a < 32) return m_blk[a - 16];
        if (a >= 32 && a < 37) return core_digest[159 - 32*(a-32) -: 32];
        return '0;
    endfunction

    function automatic string rd_tag();
        int a = int'(addr);
        if (!(cs && !we)) return "R9";
        if (a <= 2) return "R2";
        if (a == 8) return "R3";
        if (a == 9) return "R6";
        if (a >= 16 && a < 32) return "R7";
        if (a >= 32 && a < 37) return "R8";
        return "R9";
    endfunction

    task automatic check(string tag, string what, logic [511:0] act, logic [511:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs against the model every cycle, after the inputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (!done) begin
                logic [511:0] eb;
                for (int i = 0; i < 16; i++) eb[511-32*i -: 32] = m_blk[i];
                check(m_inrst ? "R1" : "R7/R10", "core_block", core_block, eb);
                check(m_inrst ? "R1" : "R4", "core_init", 512'(core_init), 512'(m_ip));
                check(m_inrst ? "R1" : "R5", "core_next", 512'(core_next), 512'(m_np));
                check(rd_tag(), "rdata", 512'(rdata), 512'(exp_rd()));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = a; wdata = 32'hdeadbeef;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cs = 1'b0; we = 1'b0;
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h08);
        // R2: identification words and ignored writes
        rd(8'h00); rd(8'h01); rd(8'h02);
        wr(8'h01, 32'h0); rd(8'h01);
        // R7: block words, distinct per index, then read back
        for (int i = 0; i < 16; i++) wr(8'(16 + i), 32'h11000000 * (i + 1) ^ 32'(i * 3));
        idle(2);
        for (int i = 15; i >= 0; i--) rd(8'(16 + i));
        // R3/R4/R5: command pulses
        wr(8'h08, 32'h1); idle(3);
        wr(8'h08, 32'h1); idle(2);
        wr(8'h08, 32'h0); rd(8'h08);
        wr(8'h08, 32'h2); idle(2);
        wr(8'h08, 32'h3); idle(2);
        wr(8'h08, 32'hfffffffc); rd(8'h08);
        wr(8'h08, 32'hffffffff); rd(8'h08);
        wr(8'h08, 32'h0);
        // R6: status combinations and ignored write
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); core_ready = s[0]; core_valid = s[1];
            cs = 1'b1; we = 1'b0; addr = 8'h09;
        end
        wr(8'h09, 32'hffffffff); rd(8'h09);
        // R8: digest words and ignored write
        core_digest = 160'h0123456789abcdef_fedcba9876543210_a5a55a5a;
        for (int j = 0; j < 5; j++) rd(8'(32 + j));
        wr(8'h22, 32'h0); rd(8'h22);
        core_digest = ~core_digest;
        for (int j = 4; j >= 0; j--) rd(8'(32 + j));
        // R9: unmapped reads and idle bus
        rd(8'h03); rd(8'h07); rd(8'h0a); rd(8'h0f); rd(8'h25); rd(8'hff);
        @(negedge clk); cs = 1'b0; we = 1'b0; addr = 8'h10;
        // R10: we without cs changes nothing
        @(negedge clk); cs = 1'b0; we = 1'b1; addr = 8'h12; wdata = 32'h0;
        @(negedge clk); cs = 1'b0; we = 1'b1; addr = 8'h08; wdata = 32'h3;
        rd(8'h12); rd(8'h08);
        // R1: reset in mid-run clears block and command
        @(negedge clk); cs = 1'b0; we = 1'b0; rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h10); rd(8'h08);
        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule